// File: doc/BRIEF.md
# 64-bit Compare Timer with Periodic Reload

This block is a free-running 64-bit up-counter with a programmable clock divider and a 64-bit match register. When the counter steps onto the match value, a sticky event bit is raised and, if enabled, a level interrupt is driven. In periodic mode every match adds a 32-bit step to the match register, so events recur at a fixed interval while the counter itself runs on untouched.

Software reaches the block through a plain 32-bit register port: address, write data, write strobe, read strobe and read data. Reads are combinational in the cycle the read strobe is high. Writes take effect at the clock edge that samples the write strobe. The 64-bit quantities are split into low and high words.

Top module: `cmp_timer64`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: While control bit 0 (run) is 0 the counter keeps its value, and all registers can still be written and read back.
- R3: With run set, the counter gains exactly one every (D+1) clock edges, where D is control bits 15:8; the divider starts from zero each time run goes from 0 to 1.
- R4: Writing offset 0x200 (low word) or 0x204 (high word) loads that half of the counter directly; counting carries from the low word into the high word.
- R5: The event bit (status offset 0x20C, bit 0) is set on the edge where the counter steps to a value equal to the match register (0x210 low, 0x214 high), provided control bit 1 (compare on) is 1; with compare off no event is raised.
- R6: The event bit stays set until a write with bit 0 = 1 to the status offset; a write with bit 0 = 0 leaves it unchanged.
- R7: With control bit 3 (periodic) at 0, a match leaves the match register unchanged.
- R8: With periodic mode and compare on, each match adds the step register (offset 0x218) to the match register on that same edge, so the next event comes exactly one step later; the counter is not disturbed.
- R9: `irq` is high exactly while the event bit is 1 and control bit 2 (interrupt on) is 1.
- R10: Reading the control register (offset 0x208) returns 0 in bits 7:4 and 31:16.
- R11: `rdData` is 0 whenever `rdEn` is low, and for unmapped offsets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Register byte offset |
| wrData | input | 32 | Write data |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Read data, valid while rdEn is high |
| irq | output | 1 | Level interrupt |

## Verification
A divider that restarts at the wrong point or counts one edge too many shows as a counter value that differs by one after a timed run, read back as soon as the counter is stopped. A match compare done against the old rather than the stepped count shifts the interrupt by one cycle, which the per-cycle poll of `irq` catches on the very edge it should rise. A reload that lands late or is skipped leaves a match register off by a whole step, visible at the next read of the match words.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;
  parameter int WORD_W  = 32;
  parameter int PRESC_W = 8;
  localparam int WIDE_W = 2 * WORD_W;

  localparam logic [11:0] OFS_CNT_LO = 12'h200;
  localparam logic [11:0] OFS_CNT_HI = 12'h204;
  localparam logic [11:0] OFS_CTRL   = 12'h208;
  localparam logic [11:0] OFS_STAT   = 12'h20C;
  localparam logic [11:0] OFS_CMP_LO = 12'h210;
  localparam logic [11:0] OFS_CMP_HI = 12'h214;
  localparam logic [11:0] OFS_STEP   = 12'h218;

  // Strobes and configuration handed from control to datapath.
  typedef struct packed {
    logic               run;
    logic               cmpOn;
    logic               autoOn;
    logic [PRESC_W-1:0] presc;
    logic               ldCntLo;
    logic               ldCntHi;
    logic               ldCmpLo;
    logic               ldCmpHi;
    logic               ldStep;
    logic               clrFlag;
    logic [WORD_W-1:0]  wdata;
  } ctlStrobe_t;
endpackage

// File: rtl/ctimer_dpath.sv
module ctimer_dpath
  import ctimer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  output logic [WIDE_W-1:0] cntVal,
  output logic [WIDE_W-1:0] cmpVal,
  output logic [WORD_W-1:0] stepVal,
  output logic              flag
);
  logic [PRESC_W-1:0] divCnt;
  logic               tick;
  logic [WIDE_W-1:0]  cntNext;
  logic               hit;
  logic               ldCnt;
  logic               ldCmp;

  assign tick    = strb.run && (divCnt == strb.presc);
  assign cntNext = cntVal + 1'b1;
  assign hit     = tick && strb.cmpOn && (cntNext == cmpVal);
  assign ldCnt   = strb.ldCntLo || strb.ldCntHi;
  assign ldCmp   = strb.ldCmpLo || strb.ldCmpHi;

  // Divider: held at zero while stopped, so each start begins a fresh period.
  always_ff @(posedge clk) begin
    if (!rstN || !strb.run || tick) divCnt <= '0;
    else                            divCnt <= divCnt + 1'b1;
  end

  // Counter: a direct load wins over the step.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (ldCnt) begin
      if (strb.ldCntLo) cntVal[WORD_W-1:0]      <= strb.wdata;
      if (strb.ldCntHi) cntVal[WIDE_W-1:WORD_W] <= strb.wdata;
    end else if (tick) begin
      cntVal <= cntNext;
    end
  end

  // Match register: a software write wins over the periodic reload.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpVal <= '0;
    end else if (ldCmp) begin
      if (strb.ldCmpLo) cmpVal[WORD_W-1:0]      <= strb.wdata;
      if (strb.ldCmpHi) cmpVal[WIDE_W-1:WORD_W] <= strb.wdata;
    end else if (hit && strb.autoOn) begin
      cmpVal <= cmpVal + {{WORD_W{1'b0}}, stepVal};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            stepVal <= '0;
    else if (strb.ldStep) stepVal <= strb.wdata;
  end

  // Event bit: a new match beats a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN)             flag <= 1'b0;
    else if (hit)          flag <= 1'b1;
    else if (strb.clrFlag) flag <= 1'b0;
  end

  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !ldCnt) |=> $stable(cntVal));
  p_step_by_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ldCnt) |=> (cntVal == $past(cntVal) || cntVal == $past(cntVal) + 1'b1));
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !strb.clrFlag) |=> flag);
  p_single_keeps_cmp_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.autoOn && !ldCmp) |=> $stable(cmpVal));
  p_reload_adds_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hit && strb.autoOn && !ldCmp && !strb.ldStep) |=>
      (cmpVal == $past(cmpVal) + {{WORD_W{1'b0}}, stepVal}));
endmodule

// File: rtl/ctimer_ctrl.sv
module ctimer_ctrl
  import ctimer_pkg::*;
#(
  parameter int ADDR_W = 12
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  output logic              irq,
  input  logic [WIDE_W-1:0] cntVal,
  input  logic [WIDE_W-1:0] cmpVal,
  input  logic [WORD_W-1:0] stepVal,
  input  logic              flag,
  output ctlStrobe_t        strb
);
  localparam int PRESC_LSB = 8;

  logic               runQ, cmpOnQ, irqOnQ, autoOnQ;
  logic [PRESC_W-1:0] prescQ;
  logic               selCtrl;
  logic [WORD_W-1:0]  ctrlWord;

  function automatic logic hitOfs(input logic [ADDR_W-1:0] a, input logic [11:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign selCtrl = hitOfs(addr, OFS_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= 1'b0; cmpOnQ <= 1'b0; irqOnQ <= 1'b0; autoOnQ <= 1'b0;
      prescQ <= '0;
    end else if (wrEn && selCtrl) begin
      runQ    <= wrData[0];
      cmpOnQ  <= wrData[1];
      irqOnQ  <= wrData[2];
      autoOnQ <= wrData[3];
      prescQ  <= wrData[PRESC_LSB +: PRESC_W];
    end
  end

  always_comb begin
    strb         = '0;
    strb.run     = runQ;
    strb.cmpOn   = cmpOnQ;
    strb.autoOn  = autoOnQ;
    strb.presc   = prescQ;
    strb.wdata   = wrData;
    strb.ldCntLo = wrEn && hitOfs(addr, OFS_CNT_LO);
    strb.ldCntHi = wrEn && hitOfs(addr, OFS_CNT_HI);
    strb.ldCmpLo = wrEn && hitOfs(addr, OFS_CMP_LO);
    strb.ldCmpHi = wrEn && hitOfs(addr, OFS_CMP_HI);
    strb.ldStep  = wrEn && hitOfs(addr, OFS_STEP);
    strb.clrFlag = wrEn && hitOfs(addr, OFS_STAT) && wrData[0];
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[0] = runQ;
    ctrlWord[1] = cmpOnQ;
    ctrlWord[2] = irqOnQ;
    ctrlWord[3] = autoOnQ;
    ctrlWord[PRESC_LSB +: PRESC_W] = prescQ;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if      (hitOfs(addr, OFS_CNT_LO)) rdData = cntVal[WORD_W-1:0];
      else if (hitOfs(addr, OFS_CNT_HI)) rdData = cntVal[WIDE_W-1:WORD_W];
      else if (selCtrl)                  rdData = ctrlWord;
      else if (hitOfs(addr, OFS_STAT))   rdData = {{(WORD_W-1){1'b0}}, flag};
      else if (hitOfs(addr, OFS_CMP_LO)) rdData = cmpVal[WORD_W-1:0];
      else if (hitOfs(addr, OFS_CMP_HI)) rdData = cmpVal[WIDE_W-1:WORD_W];
      else if (hitOfs(addr, OFS_STEP))   rdData = stepVal;
    end
  end

  assign irq = flag && irqOnQ;

  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && selCtrl) |-> (rdData[7:4] == 4'h0 && rdData[WORD_W-1:16] == '0));
  p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn) |-> (rdData == '0));
  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> flag);
endmodule

// File: rtl/cmp_timer64.sv
module cmp_timer64
  import ctimer_pkg::*;
#(
  parameter int ADDR_W = 12
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [31:0]       rdData,
  output logic              irq
);
  ctlStrobe_t        strb;
  logic [WIDE_W-1:0] cntVal;
  logic [WIDE_W-1:0] cmpVal;
  logic [WORD_W-1:0] stepVal;
  logic              flag;

  ctimer_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .irq(irq), .cntVal(cntVal),
    .cmpVal(cmpVal), .stepVal(stepVal), .flag(flag), .strb(strb)
  );

  ctimer_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cntVal(cntVal),
    .cmpVal(cmpVal), .stepVal(stepVal), .flag(flag)
  );
endmodule

// File: tb/cmp_timer64_tb.sv
module cmp_timer64_tb;
  localparam logic [11:0] A_CLO = 12'h200, A_CHI = 12'h204, A_CTL = 12'h208,
                          A_STA = 12'h20C, A_MLO = 12'h210, A_MHI = 12'h214,
                          A_STP = 12'h218;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  cmp_timer64 u_dut (.clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData), .irq(irq));

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the following posedge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic rd64(input logic [11:0] a, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(a, lo); rd(a + 12'h4, hi);
    d = {hi, lo};
  endtask

  task automatic wr64(input logic [11:0] a, input logic [63:0] d);
    wr(a, d[31:0]); wr(a + 12'h4, d[63:32]);
  endtask

  // Edges with run set = n+1 when n idle cycles separate start and stop writes.
  function automatic longint unsigned expTicks(input int n, input int p);
    return longint'((n + 1) / (p + 1));
  endfunction

  // Match value after a run in periodic mode.
  function automatic logic [63:0] expCmp(input logic [63:0] c0, input longint unsigned off,
                                         input longint unsigned t, input longint unsigned st,
                                         input bit per);
    if (!per || off < 1 || off > t) return c0 + off;
    return c0 + off + ((t - off) / st + 1) * st;
  endfunction

  // Start, idle n cycles, stop.
  task automatic runFor(input logic [31:0] ctl, input int n);
    wr(A_CTL, ctl);
    repeat (n) @(negedge clk);
    wr(A_CTL, ctl & 32'hFFFF_FFFE);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] v, c0;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTL, r); check("R1 ctrl", r, 0);
    rd(A_STA, r); check("R1 status", r, 0);
    rd64(A_CLO, v); check("R1 counter", v, 0);
    rd64(A_MLO, v); check("R1 match", v, 0);
    rd(A_STP, r); check("R1 step", r, 0);
    check("R1 irq", irq, 0);

    // R10 reserved bits, R11 idle bus
    wr(A_CTL, 32'hFFFF_FFF0);
    rd(A_CTL, r); check("R10 ctrl readback", r, 32'h0000_FF00);
    addr = A_CTL; #1 check("R11 rdEn low", rdData, 0);
    rd(12'h21C, r); check("R11 unmapped", r, 0);
    wr(A_CTL, 0);

    // R2 stopped counter holds, registers writable
    wr64(A_CLO, 64'h1234_5678_9ABC_DEF0);
    wr(A_STP, 32'hCAFE_0001);
    repeat (10) @(negedge clk);
    rd64(A_CLO, v); check("R2 hold", v, 64'h1234_5678_9ABC_DEF0);
    rd(A_STP, r); check("R2 step rw", r, 32'hCAFE_0001);

    // R3 divider, R4 carry across words
    wr64(A_CLO, 64'h0000_0000_FFFF_FFFE);
    runFor(32'h0000_0201, 10);  // divide by 3, 11 edges -> 3 steps
    rd64(A_CLO, v); check("R4 carry", v, 64'h0000_0001_0000_0001);
    runFor(32'h0000_0201, 1);   // 2 edges, fresh divider -> 0 steps
    rd64(A_CLO, v); check("R3 restart", v, 64'h0000_0001_0000_0001);

    // R5/R9 exact edge of event, polled on irq
    c0 = 64'h0000_00FF_FFFF_FFFD;
    wr64(A_CLO, c0); wr64(A_MLO, c0 + 5);
    wr(A_CTL, 32'h7);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check($sformatf("R5 R9 irq at step %0d", k), irq, (k >= 5));
    end
    wr(A_CTL, 32'h6);
    // R6 write 0 ignored, write 1 clears; R9 masked
    wr(A_STA, 0); rd(A_STA, r); check("R6 write zero", r, 1);
    check("R9 irq on", irq, 1);
    wr(A_CTL, 32'h2); check("R9 irq masked", irq, 0);
    rd(A_STA, r); check("R9 flag kept", r, 1);
    wr(A_STA, 1); rd(A_STA, r); check("R6 clear", r, 0);
    rd64(A_MLO, v); check("R7 match unchanged", v, c0 + 5);

    // R5 compare off: no event
    wr64(A_CLO, 0); wr64(A_MLO, 3);
    runFor(32'h1, 10);
    rd(A_STA, r); check("R5 compare off", r, 0);

    // R8 periodic reload with carry
    c0 = 64'h0000_0000_FFFF_FFF0;
    wr64(A_CLO, c0); wr64(A_MLO, c0 + 5); wr(A_STP, 7);
    runFor(32'hB, 30);
    rd64(A_CLO, v); check("R8 counter undisturbed", v, c0 + 31);
    rd64(A_MLO, v); check("R8 match advanced", v, expCmp(c0, 5, 31, 7, 1'b1));
    wr(A_STA, 1);

    // Random runs in both modes
    for (int it = 0; it < 24; it++) begin
      int p, n; longint unsigned t, off, st; bit per;
      c0 = {$urandom(), $urandom()};
      p = $urandom % 6; n = $urandom % 60 + 5; per = $urandom % 2;
      st = $urandom % 7 + 1;
      t = expTicks(n, p);
      off = $urandom % (t + 4);
      wr64(A_CLO, c0); wr64(A_MLO, c0 + off); wr(A_STP, 32'(st));
      wr(A_STA, 1);
      runFor({16'h0, 8'(p), 4'h0, per, 1'b0, 1'b1, 1'b1}, n);
      rd64(A_CLO, v); check("R3 random count", v, c0 + t);
      rd(A_STA, r); check("R5 random event", r, (off >= 1 && off <= t));
      rd64(A_MLO, v);
      check(per ? "R8 random match" : "R7 random match", v, expCmp(c0, off, t, st, per));
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule